// File: doc/BRIEF.md
# Discrete Pin Configuration and Snapshot Block

This block sits on a processor's local bus and owns two general-purpose pins that can each act as an input or an output. A write to the configuration address sets, for each pin, a direction bit, a static level and two source-select bits. A pin configured as an output drives one of four things:

- the externally supplied timemark pulse, which has the highest priority;
- otherwise a 100 kHz square wave divided down from the block clock;
- otherwise the static level bit, which gives a constant low or a constant high.

A pin configured as an input holds its drive value and its output enable low.

A read of the same configuration address does not return the configuration. It captures, in one cycle, the levels of sixteen unrelated input pins. Those levels are first passed through a two-stage synchronizer. A separate debug address returns the stored configuration word, with the unused bits read as zero.

A byte-wide retention register lets software leave a marker value. A master reset does not clear it; only the power-on reset does. Software reads the marker back after a restart to tell a soft reset from a full loss of power.

Top module: `dio_ctrl`

## Requirements
- R1: While `rst` or `por` is high, and on the first cycle after either is released, `pin_oe` and `pin_out` are both 2'b00. A debug read issued after the release returns 16'h0000.
- R2: A read strobe with `addr` equal to `ADDR_CFG` loads `rdata` at that clock edge with `pins_in`, bit i for bit i. The value captured is the one `pins_in` held two clock edges before the capture edge. A change made only one edge earlier is not yet visible.
- R3: `rdata` changes only on a clock edge where `rd_en` is high. Between reads it holds its value even when `pins_in` changes.
- R4: Pin A (index 0) is an output exactly when write bit 0 is set. Pin B (index 1) is an output exactly when write bit 8 is set. Bit 9 is stored but has no effect on the direction. A pin that is not an output has `pin_oe` low and `pin_out` low.
- R5: For an output pin, the drive value follows a priority order. The timemark select bit (bit 3 for A, bit 12 for B) makes the pin follow `timemark`. Otherwise the square-wave select bit (bit 2 for A, bit 11 for B) makes it follow the square wave. Otherwise the pin drives the level bit (bit 1 for A, bit 10 for B).
- R6: The square wave has a period of CLK_HZ/100000 clock cycles and is high for exactly half of them. CLK_HZ must be a multiple of 200000.
- R7: A write to `ADDR_RET` stores `wdata[7:0]`. A read of `ADDR_RET` returns the stored byte zero-extended to 16 bits. `rst` leaves the byte unchanged and `por` clears it.
- R8: A read of `ADDR_DBG` returns the stored configuration word masked with 16'h1F0F, so bits 15..13 and 7..4 read as zero.
- R9: A read of any address other than the three mapped ones returns 16'h0000. A write to any address other than `ADDR_CFG` or `ADDR_RET` leaves the configuration and the pins unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the source of the square wave |
| rst | input | 1 | Synchronous master reset, active high |
| por | input | 1 | Synchronous power-on reset, active high; also clears the retention byte |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| pins_in | input | 16 | Asynchronous input pin levels for the snapshot |
| timemark | input | 1 | Externally generated timemark pulse |
| pin_out | output | 2 | Drive value, index 0 pin A, index 1 pin B |
| pin_oe | output | 2 | Output enable, index 0 pin A, index 1 pin B |

## Verification
The bench builds the block with CLK_HZ set to 1 MHz. That gives a square wave with a half period of five cycles. A 40-cycle window then holds exactly four periods, so the count of high cycles and the count of edges in that window can be checked exactly. The address width and the map keep their defaults. With those values, every mapped address can be reached, along with one unmapped address, using short directed writes and reads.

// File: rtl/dio_pkg.sv
package dio_pkg;

    localparam int unsigned WORD_W   = 16;
    localparam int unsigned NUM_PINS = 2;
    localparam int unsigned SQ_HZ    = 100000;

    // Configuration bits that are stored; every other bit reads back as zero.
    localparam logic [WORD_W-1:0] CFG_MASK = 16'h1F0F;

    // Settings for one bidirectional pin.
    typedef struct packed {
        logic tm_sel;   // follow the timemark input
        logic sq_sel;   // follow the square wave
        logic level;    // static drive value
        logic dir;      // 1 = output
    } pin_cfg_t;

    // Pin A sits in bits 3..0 of the configuration word.
    function automatic pin_cfg_t cfg_of_a(input logic [WORD_W-1:0] w);
        return pin_cfg_t'(w[3:0]);
    endfunction

    // Pin B: bit 12 timemark, bit 11 square wave, bit 10 level, bit 8 direction.
    function automatic pin_cfg_t cfg_of_b(input logic [WORD_W-1:0] w);
        pin_cfg_t c;
        c.tm_sel = w[12];
        c.sq_sel = w[11];
        c.level  = w[10];
        c.dir    = w[8];
        return c;
    endfunction

    // Drive value of an output pin, by priority.
    function automatic logic pick_source(input pin_cfg_t c, input logic tm,
                                         input logic sq);
        if (c.tm_sel)      return tm;
        else if (c.sq_sel) return sq;
        else               return c.level;
    endfunction

endpackage

// File: rtl/dio_regs.sv
module dio_regs
    import dio_pkg::*;
#(
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned ADDR_CFG = 0,
    parameter int unsigned ADDR_RET = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] cfg_word,
    output logic [7:0]        ret_q
);

    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(ADDR_CFG);
    localparam logic [ADDR_W-1:0] A_RET = ADDR_W'(ADDR_RET);

    always_ff @(posedge clk) begin
        if (rst || por) begin
            cfg_word <= '0;
        end else if (wr_en && addr == A_CFG) begin
            cfg_word <= wdata & CFG_MASK;
        end
    end

    // The retention byte survives a master reset.
    always_ff @(posedge clk) begin
        if (por) begin
            ret_q <= '0;
        end else if (!rst && wr_en && addr == A_RET) begin
            ret_q <= wdata[7:0];
        end
    end

endmodule

// File: rtl/dio_sync.sv
module dio_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/dio_sqwave.sv
module dio_sqwave #(
    parameter int unsigned HALF = 50
) (
    input  logic clk,
    input  logic rst,
    output logic sq
);

    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            sq  <= 1'b0;
        end else if (cnt == LAST) begin
            cnt <= '0;
            sq  <= ~sq;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dio_pinmux.sv
module dio_pinmux
    import dio_pkg::*;
(
    input  pin_cfg_t cfg,
    input  logic     tm,
    input  logic     sq,
    output logic     drv,
    output logic     oe
);

    always_comb begin
        oe  = cfg.dir;
        drv = cfg.dir ? pick_source(cfg, tm, sq) : 1'b0;
    end

endmodule

// File: rtl/dio_ctrl.sv
module dio_ctrl
    import dio_pkg::*;
#(
    parameter int unsigned CLK_HZ   = 10000000,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned ADDR_CFG = 0,
    parameter int unsigned ADDR_RET = 1,
    parameter int unsigned ADDR_DBG = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    input  logic [15:0]       pins_in,
    input  logic              timemark,
    output logic [1:0]        pin_out,
    output logic [1:0]        pin_oe
);

    localparam int unsigned HALF = CLK_HZ / (2 * SQ_HZ);
    localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(ADDR_CFG);
    localparam logic [ADDR_W-1:0] A_RET = ADDR_W'(ADDR_RET);
    localparam logic [ADDR_W-1:0] A_DBG = ADDR_W'(ADDR_DBG);

    logic              rst_any;
    logic [WORD_W-1:0] cfg_word;
    logic [7:0]        ret_q;
    logic [WORD_W-1:0] pins_sync;
    logic              sq_wave;
    pin_cfg_t          cfg [NUM_PINS];

    assign rst_any = rst | por;

    dio_regs #(
        .ADDR_W(ADDR_W), .ADDR_CFG(ADDR_CFG), .ADDR_RET(ADDR_RET)
    ) u_regs (
        .clk(clk), .rst(rst), .por(por), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .cfg_word(cfg_word), .ret_q(ret_q)
    );

    dio_sync #(.W(WORD_W)) u_sync (
        .clk(clk), .rst(rst_any), .d(pins_in), .q(pins_sync)
    );

    dio_sqwave #(.HALF(HALF)) u_sq (
        .clk(clk), .rst(rst_any), .sq(sq_wave)
    );

    assign cfg[0] = cfg_of_a(cfg_word);
    assign cfg[1] = cfg_of_b(cfg_word);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        dio_pinmux u_mux (
            .cfg(cfg[g]), .tm(timemark), .sq(sq_wave),
            .drv(pin_out[g]), .oe(pin_oe[g])
        );
    end

    // Registered read port; the snapshot is taken on the read edge.
    always_ff @(posedge clk) begin
        if (rst_any) begin
            rdata <= '0;
        end else if (rd_en) begin
            case (addr)
                A_CFG:   rdata <= pins_sync;
                A_RET:   rdata <= {8'h00, ret_q};
                A_DBG:   rdata <= cfg_word;
                default: rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/dio_ctrl_chk.sv
module dio_ctrl_chk #(
    parameter int unsigned CLK_HZ   = 10000000,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned ADDR_DBG = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              por,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [15:0]       rdata,
    input logic [1:0]        pin_out,
    input logic [1:0]        pin_oe,
    input logic              sq,
    input logic [7:0]        ret_q
);

    localparam int unsigned HALF = CLK_HZ / 200000;
    localparam logic [ADDR_W-1:0] A_DBG = ADDR_W'(ADDR_DBG);

    logic        sq_d;
    logic [31:0] run;

    // Cycles since the square wave last changed, used for R6.
    always_ff @(posedge clk) begin
        if (rst || por) begin
            sq_d <= 1'b0;
            run  <= '1;
        end else begin
            sq_d <= sq;
            run  <= (sq != sq_d) ? 32'd0 : run + 32'd1;
        end
    end

    initial begin
        a_r6_exact_divide: assert (CLK_HZ % 200000 == 0 && HALF > 0);
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst || por) |-> (pin_oe == 2'b00 && pin_out == 2'b00));

    a_r3_read_hold: assert property (@(posedge clk) disable iff (rst || por)
        !$past(rd_en) && !$past(rst || por) |-> $stable(rdata));

    a_r4_input_quiet: assert property (@(posedge clk) disable iff (rst || por)
        (!pin_oe[0] |-> !pin_out[0]) and (!pin_oe[1] |-> !pin_out[1]));

    a_r6_half_period: assert property (@(posedge clk) disable iff (rst || por)
        (sq != sq_d) |-> run == HALF - 1);

    a_r7_ret_keeps: assert property (@(posedge clk) disable iff (por)
        $past(rst) && !$past(por) |-> ret_q == $past(ret_q));

    a_r8_dbg_mask: assert property (@(posedge clk) disable iff (rst || por)
        $past(rd_en && addr == A_DBG) && !$past(rst || por)
            |-> (rdata & 16'hE0F0) == 16'h0000);

endmodule

bind dio_ctrl dio_ctrl_chk #(
    .CLK_HZ(CLK_HZ), .ADDR_W(ADDR_W), .ADDR_DBG(ADDR_DBG)
) u_chk (
    .clk(clk), .rst(rst), .por(por), .rd_en(rd_en), .addr(addr),
    .rdata(rdata), .pin_out(pin_out), .pin_oe(pin_oe), .sq(sq_wave),
    .ret_q(ret_q)
);

// File: tb/sim_dio_ctrl.sv
module sim_dio_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int unsigned CLK_HZ = 1000000;
    localparam int NVEC = 14;

    // {wdata[15:0], timemark, a_out, a_oe, b_out, b_oe}
    localparam logic [20:0] VEC [NVEC] = '{
        {16'h0000, 1'b0, 4'b0000},
        {16'h0003, 1'b0, 4'b1100},
        {16'h0001, 1'b0, 4'b0100},
        {16'h0009, 1'b1, 4'b1100},
        {16'h0009, 1'b0, 4'b0100},
        {16'h000B, 1'b0, 4'b0100},
        {16'h000D, 1'b1, 4'b1100},
        {16'h000A, 1'b1, 4'b0000},
        {16'h0500, 1'b0, 4'b0011},
        {16'h1100, 1'b1, 4'b0011},
        {16'h1500, 1'b0, 4'b0001},
        {16'h0400, 1'b0, 4'b0000},
        {16'h0200, 1'b0, 4'b0000},
        {16'h1F0F, 1'b1, 4'b1111}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        por = 1'b1;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [15:0] pins_in = '0;
    logic        timemark = 1'b0;
    logic [1:0]  pin_out;
    logic [1:0]  pin_oe;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dio_ctrl #(.CLK_HZ(CLK_HZ)) u0 (
        .clk(clk), .rst(rst), .por(por), .addr(addr), .wr_en(wr_en),
        .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .pins_in(pins_in),
        .timemark(timemark), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic pulse(input bit which_por);
        @(negedge clk);
        if (which_por) por = 1'b1; else rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        por = 1'b0; rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        int highs;
        int edges;
        logic prev;

        repeat (3) @(negedge clk);
        // R1: outputs quiet during reset
        check("R1 oe in reset", {14'd0, pin_oe}, 16'h0000);
        check("R1 out in reset", {14'd0, pin_out}, 16'h0000);
        rst = 1'b0; por = 1'b0;
        @(negedge clk);
        check("R1 oe after reset", {14'd0, pin_oe}, 16'h0000);
        check("R1 rdata after reset", rdata, 16'h0000);
        bus_read(4'd2, r);
        check("R1 debug after reset", r, 16'h0000);

        // R4 and R5 through the vector table
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            timemark = VEC[i][4];
            bus_write(4'd0, VEC[i][20:5]);
            check($sformatf("R4/R5 vec %0d pin A", i),
                  {14'd0, pin_out[0], pin_oe[0]}, {14'd0, VEC[i][3:2]});
            check($sformatf("R4/R5 vec %0d pin B", i),
                  {14'd0, pin_out[1], pin_oe[1]}, {14'd0, VEC[i][1:0]});
        end
        timemark = 1'b0;

        // R8: debug readback masks the unused bits
        bus_write(4'd0, 16'hFFFF);
        bus_read(4'd2, r);
        check("R8 debug mask", r, 16'h1F0F);

        // R2: snapshot of the pins, not the configuration
        pins_in = 16'hA55A;
        repeat (3) @(negedge clk);
        bus_read(4'd0, r);
        check("R2 snapshot", r, 16'hA55A);

        // R2: a change made one edge earlier is not yet visible
        pins_in = 16'h3C81;
        bus_read(4'd0, r);
        check("R2 sync latency old", r, 16'hA55A);
        bus_read(4'd0, r);
        check("R2 sync latency new", r, 16'h3C81);

        // R3: rdata holds between reads
        pins_in = 16'h0F0F;
        repeat (5) @(negedge clk);
        check("R3 hold", rdata, 16'h3C81);

        // R9: unmapped read and write to a read-only address
        bus_read(4'd7, r);
        check("R9 unmapped read", r, 16'h0000);
        bus_write(4'd0, 16'h0003);
        bus_write(4'd2, 16'h0000);
        bus_write(4'd9, 16'h0000);
        check("R9 ignored write oe", {14'd0, pin_oe}, 16'h0001);
        check("R9 ignored write out", {14'd0, pin_out}, 16'h0001);

        // R6: square wave on pin A
        bus_write(4'd0, 16'h0005);
        highs = 0; edges = 0;
        @(negedge clk);
        prev = pin_out[0];
        for (int k = 0; k < 40; k++) begin
            if (prev) highs++;
            @(negedge clk);
            if (pin_out[0] != prev) edges++;
            prev = pin_out[0];
        end
        check("R6 high cycles", 16'(highs), 16'd20);
        check("R6 edges", 16'(edges), 16'd8);

        // R7: retention byte survives master reset, cleared by power-on
        bus_write(4'd1, 16'hFFA5);
        bus_read(4'd1, r);
        check("R7 ret readback", r, 16'h00A5);
        pulse(1'b0);
        bus_read(4'd1, r);
        check("R7 ret after rst", r, 16'h00A5);
        check("R1 oe after rst", {14'd0, pin_oe}, 16'h0000);
        bus_read(4'd2, r);
        check("R1 debug after rst", r, 16'h0000);
        pulse(1'b1);
        bus_read(4'd1, r);
        check("R7 ret after por", r, 16'h0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule